// File: doc/BRIEF.md
# Bus-Master Sleep Sequencer

This block moves a bus-mastering device into and out of a low-power state. A sleep pin from the system starts the entry. While the device is asleep, the block keeps the bus request line low. It answers every I/O access aimed at the device with a target-abort indication. It drives the device's side-band outputs to their reset values and hides the side-band inputs from the rest of the device. Releasing the sleep pin wakes the device. The block then flags the wake-up and holds off network start for a delay that the system programs.

Entry never cuts an arbitration handshake short. If a request is already on the bus when sleep is asked for, the block keeps that request up until grant arrives, drops it for one cycle, and only then enters sleep. A DMA request that rises while the block is entering sleep or is asleep is remembered. It is placed on the bus after wake-up. Sleep requests are not honoured until a short window after reset release has passed.

Top module: `bm_sleep_ctrl`

## Requirements
- R1: While asleep (`sleep_o`=1), `target_abort_o` follows `io_access_i`. While awake, `target_abort_o` is 0.
- R2: `bus_req_o` is never 1 while `sleep_o` is 1, even if `dma_req_i` is held high.
- R3: If `bus_req_o` is 1 when a sleep request is accepted, `bus_req_o` stays 1 until a cycle with `bus_gnt_i`=1. It is 0 one cycle after that cycle, and `sleep_o` rises one cycle after that.
- R4: While asleep, `aux_out_o` equals the parameter `AUX_OUT_RST` (default 4'hA). While awake, it equals `aux_out_d_i`.
- R5: While asleep, `aux_in_o` is all zero whatever `aux_in_i` carries. While awake, it equals `aux_in_i`.
- R6: Deasserting `sleep_pin_i` ends sleep three clock edges later. `wake_o` is 1 for exactly the one cycle after the edge where sleep ends.
- R7: After reset release, no sleep request is honoured before the fourth rising edge. With the pin held high through reset, `sleep_o` is 0 after edge 3 and 1 after edge 4.
- R8: With no request pending and the hold-off window over, `sleep_o` rises three edges after `sleep_pin_i` is asserted (two synchronizer stages plus the state register).
- R9: `net_start_hold_o` is 1 while asleep. After wake-up it stays 1 for exactly `wake_dly_i` cycles, then falls.
- R10: A rising edge on `dma_req_i` while the block is entering or in sleep is latched. `bus_req_o` rises one edge after the block returns to the awake state, even if `dma_req_i` has fallen by then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| sleep_pin_i | input | 1 | Asynchronous sleep request, 1 = sleep |
| dma_req_i | input | 1 | Bus request from the DMA engine |
| bus_gnt_i | input | 1 | Bus grant |
| io_access_i | input | 1 | Strobe for an I/O access targeting the device |
| wake_dly_i | input | DLY_W | Number of cycles network start is held after wake-up |
| aux_in_i | input | AUX_IN_W | Raw side-band inputs |
| aux_out_d_i | input | AUX_OUT_W | Functional values for side-band outputs |
| bus_req_o | output | 1 | Gated bus request |
| target_abort_o | output | 1 | Answer an I/O access with target abort |
| aux_in_o | output | AUX_IN_W | Side-band inputs after masking |
| aux_out_o | output | AUX_OUT_W | Side-band outputs after forcing |
| sleep_o | output | 1 | Sleep status |
| wake_o | output | 1 | One-cycle wake-up pulse |
| net_start_hold_o | output | 1 | Network start inhibit |

## Verification
The hardest case to reach is a sleep request that lands on a pending bus request, followed by a new DMA request that rises during sleep and has to come back out after wake-up. A cycle-by-cycle vector table produces this case. It holds the DMA request high, raises the sleep pin, withholds grant for a cycle, and then grants. It pulses the DMA request once while asleep, drops it before wake-up, and expects the request line to rise right after the block leaves sleep. A second hard case is the window just after reset release. To reach it, the bench holds the sleep pin high through reset and checks the edges one by one after release.

// File: rtl/bmsl_pkg.sv
package bmsl_pkg;
  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_WAIT_GNT = 2'd1,
    ST_DROP_REQ = 2'd2,
    ST_SLEEP    = 2'd3
  } bmsl_state_e;
endpackage

// File: rtl/bmsl_sync.sv
module bmsl_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] shft_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) shft_q <= '0;
        else        shft_q <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) shft_q <= '0;
        else        shft_q <= {shft_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = shft_q[STAGES-1];
endmodule

// File: rtl/bmsl_holdoff.sv
module bmsl_holdoff #(
  parameter int HOLDOFF_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  output logic allow_o
);
  localparam int HW = $clog2(HOLDOFF_CYC + 1);
  localparam logic [HW-1:0] HMAX = HW'(HOLDOFF_CYC);

  logic [HW-1:0] cnt_q, cnt_n;
  logic          cnt_en;

  assign cnt_en  = (cnt_q != HMAX);
  assign cnt_n   = cnt_q + 1'b1;
  assign allow_o = (cnt_q == HMAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_n;
  end

  // R7: once the window has elapsed it stays open until the next reset
  p_allow_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    allow_o |=> allow_o);
endmodule

// File: rtl/bmsl_fsm.sv
module bmsl_fsm
  import bmsl_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_s_i,
  input  logic allow_i,
  input  logic dma_req_i,
  input  logic bus_gnt_i,
  output logic bus_req_o,
  output logic asleep_o,
  output logic wake_set_o,
  output logic wake_o
);
  bmsl_state_e state_q, state_n;
  logic req_q, req_n;
  logic pend_q, pend_n;
  logic dma_d_q;
  logic wake_q;
  logic dma_rise;

  assign dma_rise = dma_req_i & ~dma_d_q;

  always_comb begin
    state_n = state_q;
    req_n   = req_q;
    case (state_q)
      ST_IDLE: begin
        req_n = dma_req_i | pend_q;
        if (sleep_s_i && allow_i) begin
          if (req_q) begin
            state_n = ST_WAIT_GNT;
            req_n   = 1'b1;
          end else begin
            state_n = ST_SLEEP;
            req_n   = 1'b0;
          end
        end
      end
      ST_WAIT_GNT: begin
        req_n = 1'b1;
        if (bus_gnt_i) begin
          state_n = ST_DROP_REQ;
          req_n   = 1'b0;
        end
      end
      ST_DROP_REQ: begin
        req_n   = 1'b0;
        state_n = ST_SLEEP;
      end
      ST_SLEEP: begin
        req_n = 1'b0;
        if (!sleep_s_i) state_n = ST_IDLE;
      end
      default: begin
        state_n = ST_IDLE;
        req_n   = 1'b0;
      end
    endcase
  end

  always_comb begin
    if (state_q == ST_IDLE) begin
      if (state_n == ST_SLEEP) pend_n = pend_q | dma_rise;
      else                     pend_n = 1'b0;
    end else begin
      pend_n = pend_q | dma_rise;
    end
  end

  assign wake_set_o = (state_q == ST_SLEEP) && (state_n == ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      req_q   <= 1'b0;
      pend_q  <= 1'b0;
      dma_d_q <= 1'b0;
      wake_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      req_q   <= req_n;
      pend_q  <= pend_n;
      dma_d_q <= dma_req_i;
      wake_q  <= wake_set_o;
    end
  end

  assign bus_req_o = req_q;
  assign asleep_o  = (state_q == ST_SLEEP);
  assign wake_o    = wake_q;

  // R2: no request on the bus in the sleep state
  p_no_req_asleep_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SLEEP) |-> !req_q);
  // R3: a pending request is held while waiting for grant
  p_hold_req_waiting_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT_GNT) |-> req_q);
  // R3: sleep is entered only from a cycle with the request already low
  p_enter_after_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SLEEP && $past(state_q) != ST_SLEEP) |-> !$past(req_q));
  // R7: leaving the awake state only happens after the hold-off window
  p_leave_idle_allowed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE) |-> allow_i);
endmodule

// File: rtl/bmsl_wake_timer.sv
module bmsl_wake_timer #(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [DLY_W-1:0] dly_i,
  input  logic             asleep_i,
  output logic             hold_o
);
  logic [DLY_W-1:0] cnt_q, cnt_n;
  logic             cnt_en;

  assign cnt_en = load_i | (cnt_q != '0);
  assign cnt_n  = load_i ? dly_i : (cnt_q - 1'b1);
  assign hold_o = asleep_i | (cnt_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_n;
  end

  // R9: the delay counts down by exactly one per cycle once loaded
  p_countdown_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0 && !load_i) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/bm_sleep_ctrl.sv
module bm_sleep_ctrl #(
  parameter int                   AUX_IN_W    = 4,
  parameter int                   AUX_OUT_W   = 4,
  parameter logic [AUX_OUT_W-1:0] AUX_OUT_RST = 4'hA,
  parameter int                   DLY_W       = 8,
  parameter int                   SYNC_STAGES = 2,
  parameter int                   HOLDOFF_CYC = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sleep_pin_i,
  input  logic                 dma_req_i,
  input  logic                 bus_gnt_i,
  input  logic                 io_access_i,
  input  logic [DLY_W-1:0]     wake_dly_i,
  input  logic [AUX_IN_W-1:0]  aux_in_i,
  input  logic [AUX_OUT_W-1:0] aux_out_d_i,
  output logic                 bus_req_o,
  output logic                 target_abort_o,
  output logic [AUX_IN_W-1:0]  aux_in_o,
  output logic [AUX_OUT_W-1:0] aux_out_o,
  output logic                 sleep_o,
  output logic                 wake_o,
  output logic                 net_start_hold_o
);
  logic sleep_s;
  logic allow;
  logic asleep;
  logic wake_set;

  bmsl_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(sleep_pin_i), .q_o(sleep_s));

  bmsl_holdoff #(.HOLDOFF_CYC(HOLDOFF_CYC)) u_holdoff (
    .clk(clk), .rst_n(rst_n), .allow_o(allow));

  bmsl_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .sleep_s_i(sleep_s), .allow_i(allow),
    .dma_req_i(dma_req_i), .bus_gnt_i(bus_gnt_i), .bus_req_o(bus_req_o),
    .asleep_o(asleep), .wake_set_o(wake_set), .wake_o(wake_o));

  bmsl_wake_timer #(.DLY_W(DLY_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load_i(wake_set), .dly_i(wake_dly_i),
    .asleep_i(asleep), .hold_o(net_start_hold_o));

  assign sleep_o        = asleep;
  assign target_abort_o = io_access_i & asleep;
  assign aux_out_o      = asleep ? AUX_OUT_RST : aux_out_d_i;
  assign aux_in_o       = asleep ? '0 : aux_in_i;

  // R9: network start is always inhibited while asleep
  p_hold_in_sleep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_o |-> net_start_hold_o);
  // R6: the wake pulse follows the cycle that left sleep
  p_wake_after_sleep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |-> (!sleep_o && $past(sleep_o)));
endmodule

// File: tb/bm_sleep_ctrl_tb_top.sv
module bm_sleep_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       sleep_pin, dma_req, bus_gnt, io_acc;
  logic [7:0] wake_dly;
  logic [3:0] aux_in, aux_out_d;
  logic       bus_req, t_abort, slp, wake, hold;
  logic [3:0] aux_in_m, aux_out;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  bm_sleep_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .sleep_pin_i(sleep_pin), .dma_req_i(dma_req),
    .bus_gnt_i(bus_gnt), .io_access_i(io_acc), .wake_dly_i(wake_dly),
    .aux_in_i(aux_in), .aux_out_d_i(aux_out_d), .bus_req_o(bus_req),
    .target_abort_o(t_abort), .aux_in_o(aux_in_m), .aux_out_o(aux_out),
    .sleep_o(slp), .wake_o(wake), .net_start_hold_o(hold));

  // row: {pin, dma, gnt, io, exp_sleep, exp_req, exp_abort}
  localparam logic [6:0] VEC [14] = '{
    7'b0100_010, 7'b1101_010, 7'b1100_010, 7'b1100_010,
    7'b1100_010, 7'b1110_000, 7'b1000_100, 7'b1001_101,
    7'b1100_100, 7'b0001_101, 7'b0000_100, 7'b0000_000,
    7'b0001_010, 7'b0000_000 };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R6 watchdog actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; sleep_pin = 1'b0; dma_req = 1'b0; bus_gnt = 1'b0; io_acc = 1'b0;
    wake_dly = 8'd0; aux_in = 4'h0; aux_out_d = 4'h0;
    step(3);
    // reset state
    chk("R2 reset bus_req", bus_req, 0);
    chk("R1 reset abort", t_abort, 0);
    chk("R6 reset sleep/wake", {slp, wake}, 0);
    chk("R9 reset hold", hold, 0);
    rst_n = 1'b1;
    step(5);

    // vector walk: R1 R2 R3 R10
    for (int v = 0; v < 14; v++) begin
      {sleep_pin, dma_req, bus_gnt, io_acc} = VEC[v][6:3];
      step(1);
      chk($sformatf("R3 row%0d sleep_o", v), slp, VEC[v][2]);
      chk($sformatf("R2/R10 row%0d bus_req_o", v), bus_req, VEC[v][1]);
      chk($sformatf("R1 row%0d target_abort_o", v), t_abort, VEC[v][0]);
    end

    // R4 R5 R8 R6 R9 directed
    wake_dly = 8'd5; aux_in = 4'hF; aux_out_d = 4'h3;
    step(1);
    chk("R4 awake aux_out", aux_out, 4'h3);
    chk("R5 awake aux_in", aux_in_m, 4'hF);
    sleep_pin = 1'b1;
    step(2);
    chk("R8 sleep not before 3 edges", slp, 0);
    step(1);
    chk("R8 sleep after 3 edges", slp, 1);
    chk("R4 forced aux_out", aux_out, 4'hA);
    chk("R5 masked aux_in", aux_in_m, 4'h0);
    chk("R9 hold in sleep", hold, 1);
    dma_req = 1'b1;
    aux_in = 4'h5;
    step(1);
    chk("R5 masked after change", aux_in_m, 4'h0);
    chk("R2 req low with dma held", bus_req, 0);
    dma_req = 1'b0;
    sleep_pin = 1'b0;
    step(2);
    chk("R6 still asleep", slp, 1);
    step(1);
    chk("R6 awake", slp, 0);
    chk("R6 wake pulse", wake, 1);
    chk("R9 hold after wake", hold, 1);
    chk("R10 latched request", bus_req, 0);
    step(1);
    chk("R6 wake pulse one cycle", wake, 0);
    chk("R10 latched request out", bus_req, 1);
    chk("R5 passthrough after wake", aux_in_m, 4'h5);
    step(3);
    chk("R9 hold at 4 cycles", hold, 1);
    step(1);
    chk("R9 hold released at 5 cycles", hold, 0);

    // R7 hold-off window after reset
    rst_n = 1'b0;
    sleep_pin = 1'b1;
    step(2);
    rst_n = 1'b1;
    step(3);
    chk("R7 no sleep after edge 3", slp, 0);
    step(1);
    chk("R7 sleep after edge 4", slp, 1);
    sleep_pin = 1'b0;
    step(4);
    chk("R6 awake at end", slp, 0);

    summary();
    $finish;
  end
endmodule